// File: doc/BRIEF.md
# Configurable Video Input Capture Front-End

The block sits between a byte-serial digital video port and two downstream consumers: a scaler and a vertical-blanking data consumer. The port delivers one byte per clock. A qualifier marks the valid bytes, and a horizontal and a vertical reference line carry the timing. For each consumer the block produces registered sample strobes, a horizontal trigger pulse, a vertical trigger pulse and a field identifier. All of these outputs appear one clock after the input edge that sampled them.

Each consumer has its own 7-bit configuration word, so the same pins can be read in two different ways at the same time. The configuration word chooses the following:
- which edges of each reference line raise a trigger
- the polarity of the qualifier
- whether every clock carries a sample (gated-clock operation)
- how the field identifier is derived
- whether timing comes from the reference pins or from embedded timing codes in the byte stream

For the scaler, a 2-bit source select picks its sample stream. The options are an internal decoder stream, this port, or nothing.

Top module: `vid_capture_frontend`

## Requirements
- R1: `src_sel_i` value 00 routes `dec_pix_i`/`dec_vld_i` to `scl_pix_o`/`scl_vld_o`, 01 routes the scaler channel's port samples, and 10 or 11 gives `scl_vld_o` = 0. The routing takes effect one clock after the select is sampled.
- R2: Configuration bit 3 sets qualifier polarity. A sample is valid when `port_qual_i` = 1 with bit 3 = 0, or when `port_qual_i` = 0 with bit 3 = 1. A valid sample shows `*_vld_o` = 1 and `*_pix_o` = the byte, one clock later.
- R3: With configuration bit 4 = 1, every clock is a valid sample whatever the qualifier level.
- R4: Configuration bit 0 picks the horizontal trigger edge: 0 = rising, 1 = falling. The edge is judged between consecutive valid samples. `*_h_trig_o` pulses for one clock, one clock after the sample that completes the edge.
- R5: Configuration bits 2:1 pick the vertical trigger edges: 00 = none, 01 = rising, 10 = falling, 11 = both. `*_v_trig_o` pulses in the same way as the horizontal trigger.
- R6: Clocks without a valid sample produce no trigger and do not update the stored reference levels.
- R7: With configuration bit 5 = 0, the field identifier takes the horizontal reference level at each selected vertical trigger edge. With bit 5 = 1, it takes the vertical reference level at each valid sample.
- R8: With configuration bit 6 = 1, timing comes from 4-byte codes of the form FF, 00, 00, XY. XY bit 6 is the field flag, bit 5 the vertical flag and bit 4 the horizontal flag. The other XY bits are ignored. The flags act as reference levels under the same edge rules as R4 and R5, the field flag drives the field identifier directly, and invalid clocks inside a code are skipped.
- R9: A code whose second or third byte is not 00 is discarded. An FF byte restarts the preamble.
- R10: The scaler channel (`cfg_scl_i`) and the blanking-data channel (`cfg_vbi_i`) apply their words independently to the same pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port sample clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel_i | input | 2 | Scaler sample source select |
| dec_pix_i | input | DATA_W | Internal decoder sample |
| dec_vld_i | input | 1 | Internal decoder sample valid |
| port_pix_i | input | DATA_W | Port data byte |
| port_qual_i | input | 1 | Port data qualifier |
| port_href_i | input | 1 | Horizontal reference pin |
| port_vref_i | input | 1 | Vertical reference pin |
| cfg_scl_i | input | 7 | Scaler interpretation word |
| cfg_vbi_i | input | 7 | Blanking-data interpretation word |
| scl_vld_o | output | 1 | Scaler sample strobe |
| scl_pix_o | output | DATA_W | Scaler sample |
| scl_h_trig_o | output | 1 | Scaler horizontal trigger |
| scl_v_trig_o | output | 1 | Scaler vertical trigger |
| scl_field_o | output | 1 | Scaler field identifier |
| vbi_vld_o | output | 1 | Blanking-data sample strobe |
| vbi_pix_o | output | DATA_W | Blanking-data sample |
| vbi_h_trig_o | output | 1 | Blanking-data horizontal trigger |
| vbi_v_trig_o | output | 1 | Blanking-data vertical trigger |
| vbi_field_o | output | 1 | Blanking-data field identifier |

## Verification
A wrong stored reference level shows up as a missing or extra trigger pulse on the first valid sample after the fault. The bench catches it by checking triggers on every directed step, including steps that follow unqualified clocks. A corrupted preamble state shows within one code of four bytes: the trigger or field output either changes on a bad code or stays put on a good one. A wrong field register is visible at once on the field pin after the next selected edge or code.

// File: rtl/vcf_pkg.sv
package vcf_pkg;

    localparam int CFG_W = 7;

    localparam logic [1:0] SRC_DEC  = 2'b00;
    localparam logic [1:0] SRC_PORT = 2'b01;

    typedef struct packed {
        logic       emb;       // timing from embedded codes
        logic       fid_fs;    // field = vertical level
        logic       gated;     // every clock valid
        logic       qual_low;  // qualifier active low
        logic [1:0] v_edge;    // [0] rising, [1] falling
        logic       h_fall;    // horizontal on falling edge
    } vcf_cfg_t;

    typedef enum logic [1:0] {
        PRE_IDLE,
        PRE_ONE,
        PRE_TWO,
        PRE_THREE
    } pre_state_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } ref_lvl_t;

    function automatic logic edge_hit(logic prev, logic cur,
                                      logic rise_en, logic fall_en);
        return (rise_en & ~prev & cur) | (fall_en & prev & ~cur);
    endfunction

endpackage

// File: rtl/vcf_sync_code.sv
module vcf_sync_code
    import vcf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] pix_i,
    input  logic              vld_i,
    output logic              hit_o,
    output ref_lvl_t          lvl_o
);

    pre_state_e state_q, state_d;
    logic       all_ones, all_zeros;

    always_comb begin
        all_ones  = (pix_i == {DATA_W{1'b1}});
        all_zeros = (pix_i == {DATA_W{1'b0}});
        hit_o     = vld_i && (state_q == PRE_THREE);
        lvl_o     = '{f: pix_i[DATA_W-2], v: pix_i[DATA_W-3], h: pix_i[DATA_W-4]};
        state_d   = state_q;
        if (vld_i) begin
            unique case (state_q)
                PRE_IDLE:  state_d = all_ones ? PRE_ONE : PRE_IDLE;
                PRE_ONE:   state_d = all_zeros ? PRE_TWO
                                   : (all_ones ? PRE_ONE : PRE_IDLE);
                PRE_TWO:   state_d = all_zeros ? PRE_THREE
                                   : (all_ones ? PRE_ONE : PRE_IDLE);
                PRE_THREE: state_d = PRE_IDLE;
                default:   state_d = PRE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PRE_IDLE;
        else     state_q <= state_d;
    end

    // R9: a code byte is only taken right after a zero byte
    p_hit_after_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == PRE_THREE) |-> $past(state_q == PRE_TWO || state_q == PRE_THREE));

endmodule

// File: rtl/vcf_channel.sv
module vcf_channel
    import vcf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic [DATA_W-1:0] pix_i,
    input  logic              qual_i,
    input  logic              href_i,
    input  logic              vref_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] pix_o,
    output logic              h_trig_o,
    output logic              v_trig_o,
    output logic              field_o
);

    vcf_cfg_t cfg;
    logic     valid, hit;
    ref_lvl_t lvl, code_q;
    logic     h_cur, v_cur, h_prev, v_prev, h_ev, v_ev;

    assign cfg   = vcf_cfg_t'(cfg_i);
    assign valid = cfg.gated | (qual_i ^ cfg.qual_low);

    vcf_sync_code #(.DATA_W(DATA_W)) u_code (
        .clk   (clk),
        .rst   (rst),
        .pix_i (pix_i),
        .vld_i (valid & cfg.emb),
        .hit_o (hit),
        .lvl_o (lvl)
    );

    always_comb begin
        if (cfg.emb) begin
            h_cur = hit ? lvl.h : code_q.h;
            v_cur = hit ? lvl.v : code_q.v;
        end else begin
            h_cur = href_i;
            v_cur = vref_i;
        end
        h_ev = edge_hit(h_prev, h_cur, ~cfg.h_fall, cfg.h_fall);
        v_ev = edge_hit(v_prev, v_cur, cfg.v_edge[0], cfg.v_edge[1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o    <= 1'b0;
            pix_o    <= '0;
            h_trig_o <= 1'b0;
            v_trig_o <= 1'b0;
            field_o  <= 1'b0;
            h_prev   <= 1'b0;
            v_prev   <= 1'b0;
            code_q   <= '0;
        end else begin
            vld_o    <= valid;
            pix_o    <= pix_i;
            h_trig_o <= valid & h_ev;
            v_trig_o <= valid & v_ev;
            if (hit) code_q <= lvl;
            if (valid) begin
                h_prev <= h_cur;
                v_prev <= v_cur;
                if (cfg.emb) begin
                    if (hit) field_o <= lvl.f;
                end else if (cfg.fid_fs) begin
                    field_o <= v_cur;
                end else if (v_ev) begin
                    field_o <= h_cur;
                end
            end
        end
    end

    p_trig_qual_r6: assert property (@(posedge clk) disable iff (rst)
        (h_trig_o || v_trig_o) |-> vld_o);

    p_gated_r3: assert property (@(posedge clk) disable iff (rst)
        cfg.gated |=> vld_o);

    p_fs_field_r7: assert property (@(posedge clk) disable iff (rst)
        (!cfg.emb && cfg.fid_fs && valid) |=> (field_o == $past(vref_i)));

    p_code_field_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg.emb && hit) |=> (field_o == $past(lvl.f)));

endmodule

// File: rtl/vid_capture_frontend.sv
module vid_capture_frontend
    import vcf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        src_sel_i,
    input  logic [DATA_W-1:0] dec_pix_i,
    input  logic              dec_vld_i,
    input  logic [DATA_W-1:0] port_pix_i,
    input  logic              port_qual_i,
    input  logic              port_href_i,
    input  logic              port_vref_i,
    input  logic [CFG_W-1:0]  cfg_scl_i,
    input  logic [CFG_W-1:0]  cfg_vbi_i,
    output logic              scl_vld_o,
    output logic [DATA_W-1:0] scl_pix_o,
    output logic              scl_h_trig_o,
    output logic              scl_v_trig_o,
    output logic              scl_field_o,
    output logic              vbi_vld_o,
    output logic [DATA_W-1:0] vbi_pix_o,
    output logic              vbi_h_trig_o,
    output logic              vbi_v_trig_o,
    output logic              vbi_field_o
);

    localparam int N_CH = 2;

    logic [CFG_W-1:0]  cfg_arr [N_CH];
    logic              ch_vld  [N_CH];
    logic [DATA_W-1:0] ch_pix  [N_CH];
    logic              ch_h    [N_CH];
    logic              ch_v    [N_CH];
    logic              ch_f    [N_CH];

    logic [1:0]        sel_q;
    logic              dec_vld_q;
    logic [DATA_W-1:0] dec_pix_q;

    assign cfg_arr[0] = cfg_scl_i;
    assign cfg_arr[1] = cfg_vbi_i;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        vcf_channel #(.DATA_W(DATA_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .cfg_i    (cfg_arr[g]),
            .pix_i    (port_pix_i),
            .qual_i   (port_qual_i),
            .href_i   (port_href_i),
            .vref_i   (port_vref_i),
            .vld_o    (ch_vld[g]),
            .pix_o    (ch_pix[g]),
            .h_trig_o (ch_h[g]),
            .v_trig_o (ch_v[g]),
            .field_o  (ch_f[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= SRC_DEC;
            dec_vld_q <= 1'b0;
            dec_pix_q <= '0;
        end else begin
            sel_q     <= src_sel_i;
            dec_vld_q <= dec_vld_i;
            dec_pix_q <= dec_pix_i;
        end
    end

    always_comb begin
        unique case (sel_q)
            SRC_DEC:  begin scl_vld_o = dec_vld_q; scl_pix_o = dec_pix_q; end
            SRC_PORT: begin scl_vld_o = ch_vld[0]; scl_pix_o = ch_pix[0]; end
            default:  begin scl_vld_o = 1'b0;      scl_pix_o = '0;        end
        endcase
    end

    assign scl_h_trig_o = ch_h[0];
    assign scl_v_trig_o = ch_v[0];
    assign scl_field_o  = ch_f[0];
    assign vbi_vld_o    = ch_vld[1];
    assign vbi_pix_o    = ch_pix[1];
    assign vbi_h_trig_o = ch_h[1];
    assign vbi_v_trig_o = ch_v[1];
    assign vbi_field_o  = ch_f[1];

    p_src_none_r1: assert property (@(posedge clk) disable iff (rst)
        src_sel_i[1] |=> !scl_vld_o);

    p_src_dec_r1: assert property (@(posedge clk) disable iff (rst)
        (src_sel_i == SRC_DEC) |=> (scl_vld_o == $past(dec_vld_i)));

endmodule

// File: tb/test_vid_capture_frontend.sv
module test_vid_capture_frontend;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] src_sel;
    logic [7:0] dec_pix, port_pix;
    logic       dec_vld, qual, href, vref;
    logic [6:0] cfg_scl, cfg_vbi;
    logic       scl_vld, scl_h, scl_v, scl_f;
    logic       vbi_vld, vbi_h, vbi_v, vbi_f;
    logic [7:0] scl_pix, vbi_pix;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    vid_capture_frontend i_vid_capture_frontend (
        .clk(clk), .rst(rst), .src_sel_i(src_sel),
        .dec_pix_i(dec_pix), .dec_vld_i(dec_vld),
        .port_pix_i(port_pix), .port_qual_i(qual),
        .port_href_i(href), .port_vref_i(vref),
        .cfg_scl_i(cfg_scl), .cfg_vbi_i(cfg_vbi),
        .scl_vld_o(scl_vld), .scl_pix_o(scl_pix),
        .scl_h_trig_o(scl_h), .scl_v_trig_o(scl_v), .scl_field_o(scl_f),
        .vbi_vld_o(vbi_vld), .vbi_pix_o(vbi_pix),
        .vbi_h_trig_o(vbi_h), .vbi_v_trig_o(vbi_v), .vbi_field_o(vbi_f)
    );

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // apply inputs, then sample one time unit after the next rising edge
    task automatic step(logic [7:0] p, logic q, logic h, logic v);
        port_pix = p; qual = q; href = h; vref = v;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(logic [6:0] cs, logic [6:0] cv);
        rst = 1'b1; src_sel = 2'b01; dec_pix = '0; dec_vld = 1'b0;
        cfg_scl = cs; cfg_vbi = cv;
        step(8'h00, 1'b0, 1'b0, 1'b0);
        step(8'h00, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(7'h10, 7'h10);
        chk("reset", "scl_vld", scl_vld, 0);
        chk("reset", "vbi_vld", vbi_vld, 0);
        chk("reset", "scl_field", scl_f, 0);
        chk("reset", "vbi_pix", vbi_pix, 0);
    endtask

    task automatic t_qual;
        do_reset(7'h00, 7'h08);
        step(8'h5A, 1'b1, 1'b0, 1'b0);
        chk("R2", "scl_vld high qual", scl_vld, 1);
        chk("R2", "scl_pix", scl_pix, 8'h5A);
        chk("R10", "vbi_vld low-active", vbi_vld, 0);
        step(8'hA5, 1'b0, 1'b0, 1'b0);
        chk("R2", "scl_vld qual low", scl_vld, 0);
        chk("R2", "vbi_vld qual low", vbi_vld, 1);
        chk("R2", "vbi_pix", vbi_pix, 8'hA5);
    endtask

    task automatic t_gated;
        do_reset(7'h10, 7'h00);
        step(8'h01, 1'b0, 1'b0, 1'b0);
        chk("R3", "gated q0", scl_vld, 1);
        chk("R3", "ungated q0", vbi_vld, 0);
        step(8'h02, 1'b1, 1'b0, 1'b0);
        chk("R3", "gated q1", scl_vld, 1);
    endtask

    task automatic t_href;
        do_reset(7'h00, 7'h01);
        step(8'h00, 1'b1, 1'b1, 1'b0);
        chk("R4", "rise scl", scl_h, 1);
        chk("R4", "rise vbi", vbi_h, 0);
        step(8'h00, 1'b1, 1'b1, 1'b0);
        chk("R4", "pulse end scl", scl_h, 0);
        chk("R4", "steady vbi", vbi_h, 0);
        step(8'h00, 1'b1, 1'b0, 1'b0);
        chk("R4", "fall scl", scl_h, 0);
        chk("R10", "fall vbi", vbi_h, 1);
    endtask

    task automatic t_unqual;
        do_reset(7'h00, 7'h00);
        step(8'h00, 1'b0, 1'b1, 1'b0);
        chk("R6", "rise unqualified", scl_h, 0);
        step(8'h00, 1'b0, 1'b0, 1'b1);
        chk("R6", "v rise unqualified", scl_v, 0);
        step(8'h00, 1'b1, 1'b1, 1'b0);
        chk("R6", "rise after gap", scl_h, 1);
    endtask

    task automatic t_vedge;
        do_reset(7'h02, 7'h04);
        step(8'h00, 1'b1, 1'b0, 1'b1);
        chk("R5", "v rise on 01", scl_v, 1);
        chk("R5", "v rise on 10", vbi_v, 0);
        step(8'h00, 1'b1, 1'b0, 1'b0);
        chk("R5", "v fall on 01", scl_v, 0);
        chk("R5", "v fall on 10", vbi_v, 1);
        cfg_scl = 7'h06; cfg_vbi = 7'h00;
        step(8'h00, 1'b1, 1'b0, 1'b1);
        chk("R5", "both rise", scl_v, 1);
        chk("R5", "none rise", vbi_v, 0);
        step(8'h00, 1'b1, 1'b0, 1'b0);
        chk("R5", "both fall", scl_v, 1);
        chk("R5", "none fall", vbi_v, 0);
    endtask

    task automatic t_field;
        do_reset(7'h02, 7'h20);
        step(8'h00, 1'b1, 1'b1, 1'b1);
        chk("R7", "phase field", scl_f, 1);
        chk("R7", "fs field", vbi_f, 1);
        step(8'h00, 1'b1, 1'b0, 1'b1);
        chk("R7", "phase hold", scl_f, 1);
        step(8'h00, 1'b1, 1'b0, 1'b0);
        chk("R7", "phase no fall", scl_f, 1);
        chk("R7", "fs low", vbi_f, 0);
        step(8'h00, 1'b1, 1'b0, 1'b1);
        chk("R7", "phase new", scl_f, 0);
    endtask

    task automatic t_embed;
        do_reset(7'h42, 7'h00);
        step(8'hFF, 1'b1, 1'b0, 1'b0);
        step(8'h00, 1'b1, 1'b0, 1'b0);
        step(8'h33, 1'b0, 1'b0, 1'b0);
        step(8'h00, 1'b1, 1'b0, 1'b0);
        chk("R8", "no trig in preamble", scl_h, 0);
        step(8'h5A, 1'b1, 1'b0, 1'b0);
        chk("R8", "code H rise", scl_h, 1);
        chk("R8", "code V none", scl_v, 0);
        chk("R8", "code field", scl_f, 1);
        chk("R10", "pin chan quiet", vbi_h, 0);
        step(8'hFF, 1'b1, 1'b0, 1'b0);
        step(8'h00, 1'b1, 1'b0, 1'b0);
        step(8'h00, 1'b1, 1'b0, 1'b0);
        step(8'h20, 1'b1, 1'b0, 1'b0);
        chk("R8", "code V rise", scl_v, 1);
        chk("R8", "code H fall ignored", scl_h, 0);
        chk("R8", "code field 0", scl_f, 0);
        step(8'hFF, 1'b1, 1'b0, 1'b0);
        step(8'h00, 1'b1, 1'b0, 1'b0);
        step(8'h01, 1'b1, 1'b0, 1'b0);
        step(8'h50, 1'b1, 1'b0, 1'b0);
        chk("R9", "bad code no H", scl_h, 0);
        chk("R9", "bad code field", scl_f, 0);
        step(8'hFF, 1'b1, 1'b0, 1'b0);
        step(8'hFF, 1'b1, 1'b0, 1'b0);
        step(8'h00, 1'b1, 1'b0, 1'b0);
        step(8'h00, 1'b1, 1'b0, 1'b0);
        step(8'h10, 1'b1, 1'b0, 1'b0);
        chk("R9", "FF restart H", scl_h, 1);
    endtask

    task automatic t_src;
        do_reset(7'h00, 7'h00);
        dec_pix = 8'hC3; dec_vld = 1'b1; src_sel = 2'b00;
        step(8'h11, 1'b1, 1'b0, 1'b0);
        chk("R1", "dec vld", scl_vld, 1);
        chk("R1", "dec pix", scl_pix, 8'hC3);
        src_sel = 2'b01;
        step(8'h22, 1'b1, 1'b0, 1'b0);
        chk("R1", "port pix", scl_pix, 8'h22);
        src_sel = 2'b10;
        step(8'h33, 1'b1, 1'b0, 1'b0);
        chk("R1", "none vld", scl_vld, 0);
        chk("R10", "vbi unaffected", vbi_pix, 8'h33);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_qual();
        t_gated();
        t_href();
        t_unqual();
        t_vedge();
        t_field();
        t_embed();
        t_src();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule